// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one 16-bit timer channel. It counts ticks of a clock-enable input and drives a single waveform output. It is programmed through a byte-wide register port with two locations. The control location picks one of six counting modes and a byte-access format. The count location takes the initial count and returns the current count. The six modes give a software-started one-shot, a gate-started one-shot, a periodic rate pulse, a square wave, a software-started strobe and a gate-started strobe. A rising edge on the gate input restarts the count in the gate-aware modes.

Inside, the channel keeps the number of ticks elapsed since counting started. The output level and the value read back are both computed from that number and the loaded count. A count of zero stands for the full range of 65536. The register port is a plain strobe interface, with no handshake and no back-pressure. A write or read acts in the single clock cycle in which its strobe is high. The read data always shows the byte that a read in that cycle would consume.

Top module: `tmr_channel`

## Requirements
- R1: After reset the channel is in mode 0 with the two-byte access format and no count loaded, `tmr_out` is low, and the count reads back as 0 (low byte, then high byte).
- R2: A written count of 0 is taken as 65536. Readback counts down from that value, wrapping to 16 bits, and the output does not fire early.
- R3: In mode 0, `tmr_out` goes low when the count is loaded. It goes high in the cycle when the elapsed ticks reach the loaded count N, and stays high from then on.
- R4: In mode 1, loading a count leaves `tmr_out` high and the counter idle. A gate rising edge starts counting: the output is low until N ticks have elapsed, then high.
- R5: In mode 2, `tmr_out` is high except while (elapsed ticks mod N) equals N−1. The period then repeats every N ticks.
- R6: In mode 3, `tmr_out` is high while (elapsed ticks mod N) is below (N+1)/2 and low for the rest of the period. For odd N the high phase is the longer one.
- R7: In modes 2 and 3, a low gate forces `tmr_out` high at once, combinationally.
- R8: In modes 1, 2, 3 and 5, a gate rising edge restarts counting from the loaded value. This also holds when a tick arrives in the same cycle; the restart wins.
- R9: In mode 4 (started by the count write) and in mode 5 (started by a gate rising edge), `tmr_out` is low for exactly the one tick interval in which the elapsed ticks equal N, and high otherwise.
- R10: Readback gives (N − elapsed) mod 65536 in modes 0, 1, 4 and 5, and N − elapsed in mode 2. In mode 3 it gives N − ((2·elapsed) mod N), with bit 0 forced to 0.
- R11: Control byte layout: bits [2:0] hold the mode, with 6 and 7 acting as 2 and 3. Bits [4:3] hold the access format: 0 is a latch command, 1 is low byte only, 2 is high byte only, 3 is low then high. With `bus_sel`=1 the write goes to control, with 0 to the count. In the two-byte format, separate write and read toggles track the byte order.
- R12: A latch command copies the current readback value, and reads return that copy until it is fully read. A latch command issued while a copy is still unread is ignored.
- R13: Writing a control word stops counting until a count is loaded. It also sets `tmr_out` to the mode's initial level: low for mode 0, high for all other modes.
- R14: When a count load and a tick fall in the same cycle, the load wins and counting restarts from the full new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable; one tick per cycle it is high |
| gate | input | 1 | Gate level; rising edge detected in `clk` |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (count location only) |
| bus_sel | input | 1 | 1 = control location, 0 = count location |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Byte a read in this cycle returns |
| tmr_out | output | 1 | Timer waveform output |

## Verification
Two events can reach the elapsed-tick register in the same cycle. One pair is a count load with a tick; the other is a gate rising edge with a tick. The bench forces each collision while the channel is already counting. It drives the final count byte, or the gate edge, in the same cycle as a tick. It then judges the result from readback and from the cycle in which the output next changes. Starting the count from the full value gives a different readback and a different transition cycle than advancing by one. The restart can therefore be told apart from a lost or applied tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    M_ONESHOT_SW = 3'd0,
    M_ONESHOT_HW = 3'd1,
    M_RATE       = 3'd2,
    M_SQUARE     = 3'd3,
    M_STROBE_SW  = 3'd4,
    M_STROBE_HW  = 3'd5
  } tmr_mode_e;

  typedef enum logic [1:0] {
    A_LATCH = 2'd0,
    A_LO    = 2'd1,
    A_HI    = 2'd2,
    A_BOTH  = 2'd3
  } tmr_acc_e;

  localparam int MODE_LSB = 0;
  localparam int ACC_LSB  = 3;

  function automatic tmr_mode_e decode_mode(input logic [2:0] f);
    case (f)
      3'd6:    return M_RATE;
      3'd7:    return M_SQUARE;
      default: return tmr_mode_e'(f);
    endcase
  endfunction

  function automatic logic is_periodic(input tmr_mode_e m);
    return (m == M_RATE) || (m == M_SQUARE);
  endfunction

  function automatic logic gate_started(input tmr_mode_e m);
    return (m == M_ONESHOT_HW) || (m == M_STROBE_HW);
  endfunction

  function automatic logic gate_restarts(input tmr_mode_e m);
    return gate_started(m) || is_periodic(m);
  endfunction
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic           re,
  input  logic           sel,
  input  logic [W/2-1:0] wdata,
  input  logic [W-1:0]   live_val,
  output tmr_mode_e      mode,
  output tmr_acc_e       acc,
  output logic           ctrl_wr,
  output logic           load,
  output logic [W:0]     load_val,
  output logic [W/2-1:0] rdata
);
  localparam int BW = W / 2;

  logic          wr_tog, rd_tog, latched;
  logic [BW-1:0] lo_buf;
  logic [W-1:0]  lat_val, raw, src;
  tmr_acc_e      acc_f;
  logic          ctl_we, cnt_we, latch_cmd;
  logic          unused_bits;

  assign acc_f       = tmr_acc_e'(wdata[ACC_LSB+1:ACC_LSB]);
  assign ctl_we      = we && sel;
  assign cnt_we      = we && !sel;
  assign latch_cmd   = ctl_we && (acc_f == A_LATCH);
  assign ctrl_wr     = ctl_we && (acc_f != A_LATCH);
  assign unused_bits = ^wdata[BW-1:ACC_LSB+2];

  always_comb begin
    raw  = '0;
    load = 1'b0;
    case (acc)
      A_LO:   begin raw = {{BW{1'b0}}, wdata}; load = cnt_we; end
      A_HI:   begin raw = {wdata, {BW{1'b0}}}; load = cnt_we; end
      A_BOTH: begin raw = {wdata, lo_buf};     load = cnt_we && wr_tog; end
      default: begin raw = '0; load = 1'b0; end
    endcase
    load_val = (raw == '0) ? {1'b1, {W{1'b0}}} : {1'b0, raw};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= M_ONESHOT_SW;
      acc     <= A_BOTH;
      wr_tog  <= 1'b0;
      rd_tog  <= 1'b0;
      latched <= 1'b0;
      lo_buf  <= '0;
      lat_val <= '0;
    end else if (ctrl_wr) begin
      mode    <= decode_mode(wdata[MODE_LSB+2:MODE_LSB]);
      acc     <= acc_f;
      wr_tog  <= 1'b0;
      rd_tog  <= 1'b0;
      latched <= 1'b0;
    end else begin
      if (latch_cmd && !latched) begin
        latched <= 1'b1;
        lat_val <= live_val;
      end
      if (cnt_we && acc == A_BOTH) begin
        if (!wr_tog) lo_buf <= wdata;
        wr_tog <= !wr_tog;
      end
      if (re && !sel) begin
        if (acc == A_BOTH) rd_tog <= !rd_tog;
        if (acc != A_BOTH || rd_tog) latched <= 1'b0;
      end
    end
  end

  assign src   = latched ? lat_val : live_val;
  assign rdata = (acc == A_HI || (acc == A_BOTH && rd_tog)) ? src[W-1:BW] : src[BW-1:0];

  // R12
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && latch_cmd) |=> (lat_val == $past(lat_val)));

  // R11
  wr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_we && acc == A_BOTH) |=> (wr_tog != $past(wr_tog)));
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         gate,
  input  tmr_mode_e    mode,
  input  logic         ctrl_wr,
  input  logic         load,
  input  logic [W:0]   load_val,
  output logic [W:0]   el,
  output logic [W:0]   n,
  output logic         run,
  output logic         reached,
  output logic         past,
  output logic [W-1:0] live_val
);
  localparam int NW = W + 1;

  logic          gate_q, loaded, trig, periodic;
  logic [NW-1:0] el_inc;
  logic [NW:0]   dbl, dbl_mod;
  logic [NW:0]   sq_full;
  logic [NW-1:0] lin_full;
  logic          unused_hi;

  assign periodic = is_periodic(mode);
  assign trig     = gate && !gate_q && loaded && gate_restarts(mode);
  assign el_inc   = el + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_q  <= 1'b0;
      loaded  <= 1'b0;
      run     <= 1'b0;
      reached <= 1'b0;
      past    <= 1'b0;
      el      <= '0;
      n       <= {1'b1, {W{1'b0}}};
    end else begin
      gate_q <= gate;
      if (ctrl_wr) begin
        loaded  <= 1'b0;
        run     <= 1'b0;
        reached <= 1'b0;
        past    <= 1'b0;
        el      <= '0;
      end else if (load) begin
        n       <= load_val;
        loaded  <= 1'b1;
        run     <= !gate_started(mode);
        reached <= 1'b0;
        past    <= 1'b0;
        el      <= '0;
      end else if (trig) begin
        run     <= 1'b1;
        reached <= 1'b0;
        past    <= 1'b0;
        el      <= '0;
      end else if (tick && run) begin
        if (periodic) begin
          el <= (el == n - 1'b1) ? '0 : el_inc;
        end else begin
          el <= el_inc;
          if (el_inc == n) reached <= 1'b1;
          if (reached) past <= 1'b1;
        end
      end
    end
  end

  // readback: square wave steps by two, others count down
  always_comb begin
    dbl     = {el, 1'b0};
    dbl_mod = (dbl >= {1'b0, n}) ? dbl - {1'b0, n} : dbl;
    sq_full = {1'b0, n} - dbl_mod;
    lin_full = n - el;
    if (mode == M_SQUARE) live_val = {sq_full[W-1:1], 1'b0};
    else                  live_val = lin_full[W-1:0];
  end
  assign unused_hi = ^{sq_full[NW:W], sq_full[0], lin_full[W]};

  // R14
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (el == '0));

  // R2
  n_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    n != '0);

  // R5
  period_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && periodic) |-> (el < n));

  // R9
  past_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    past |-> reached);

  // R3
  reached_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reached && !ctrl_wr && !load && !trig) |=> reached);
endmodule

// File: rtl/tmr_outgen.sv
module tmr_outgen
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  tmr_mode_e  mode,
  input  logic       gate,
  input  logic       run,
  input  logic       reached,
  input  logic       past,
  input  logic [W:0] el,
  input  logic [W:0] n,
  output logic       out
);
  logic [W:0] half;

  assign half = (n + 1'b1) >> 1;

  always_comb begin
    case (mode)
      M_ONESHOT_SW: out = reached;
      M_ONESHOT_HW: out = !run || reached;
      M_RATE:       out = !gate || !run || (el != n - 1'b1);
      M_SQUARE:     out = !gate || !run || (el < half);
      default:      out = !(reached && !past);
    endcase
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           gate,
  input  logic           bus_we,
  input  logic           bus_re,
  input  logic           bus_sel,
  input  logic [W/2-1:0] bus_wdata,
  output logic [W/2-1:0] bus_rdata,
  output logic           tmr_out
);
  tmr_mode_e    mode;
  tmr_acc_e     acc;
  logic         ctrl_wr, load, run, reached, past;
  logic [W:0]   load_val, el, n;
  logic [W-1:0] live_val;

  tmr_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .re(bus_re), .sel(bus_sel),
    .wdata(bus_wdata), .live_val(live_val), .mode(mode), .acc(acc),
    .ctrl_wr(ctrl_wr), .load(load), .load_val(load_val), .rdata(bus_rdata)
  );

  tmr_count #(.W(W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .mode(mode),
    .ctrl_wr(ctrl_wr), .load(load), .load_val(load_val), .el(el), .n(n),
    .run(run), .reached(reached), .past(past), .live_val(live_val)
  );

  tmr_outgen #(.W(W)) u_out (
    .mode(mode), .gate(gate), .run(run), .reached(reached), .past(past),
    .el(el), .n(n), .out(tmr_out)
  );

  // R13
  ctrl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !run);
endmodule

// File: tb/sim_tmr_channel.sv
module sim_tmr_channel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       gate = 1'b0;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic       bus_sel = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       tmr_out;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = !clk;

  tmr_channel u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .bus_we(bus_we),
    .bus_re(bus_re), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tmr_out(tmr_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cw(input int a, input int m);
    return {3'b000, a[1:0], m[2:0]};
  endfunction

  task automatic wr_ctl(input logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_sel = 1'b0;
  endtask

  task automatic wr_cnt(input logic [7:0] d);
    bus_sel = 1'b0; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic load16(input logic [15:0] v);
    wr_cnt(v[7:0]);
    wr_cnt(v[15:8]);
  endtask

  task automatic rd_byte(output logic [7:0] b);
    bus_sel = 1'b0;
    b = bus_rdata;
    bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic rd16(output int v);
    logic [7:0] lo, hi;
    rd_byte(lo);
    rd_byte(hi);
    v = {16'h0, hi, lo};
  endtask

  task automatic ticks(input int k);
    if (k > 0) begin
      tick = 1'b1;
      repeat (k) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    int v;
    chk("R1 out", tmr_out, 0);
    rd16(v);
    chk("R1 readback", v, 0);
  endtask

  task automatic t_mode0;
    int v;
    wr_ctl(cw(3, 0));
    chk("R13 mode0 initial", tmr_out, 0);
    load16(16'd5);
    chk("R3 after load", tmr_out, 0);
    ticks(4);
    chk("R3 before N", tmr_out, 0);
    wr_ctl(8'h00);
    rd16(v);
    chk("R10 mode0 readback", v, 1);
    ticks(1);
    chk("R3 at N", tmr_out, 1);
    ticks(3);
    chk("R3 stays high", tmr_out, 1);
  endtask

  task automatic t_full;
    logic [7:0] b;
    wr_ctl(cw(1, 0));
    wr_cnt(8'h00);
    rd_byte(b);
    chk("R2 zero count low byte", b, 0);
    ticks(300);
    chk("R2 no early fire", tmr_out, 0);
    rd_byte(b);
    chk("R2 wrapped readback", b, 8'hD4);
    wr_ctl(cw(2, 0));
    wr_cnt(8'h01);
    rd_byte(b);
    chk("R11 high-only read", b, 1);
    ticks(255);
    chk("R11 high-only load", tmr_out, 0);
    ticks(1);
    chk("R11 high-only fire", tmr_out, 1);
  endtask

  task automatic t_mode1;
    int v;
    gate = 1'b0;
    wr_ctl(cw(3, 1));
    chk("R13 mode1 initial", tmr_out, 1);
    load16(16'd3);
    chk("R4 idle after load", tmr_out, 1);
    ticks(5);
    chk("R4 no count before gate", tmr_out, 1);
    rd16(v);
    chk("R4 readback idle", v, 3);
    gate = 1'b1;
    @(negedge clk);
    chk("R4 trigger low", tmr_out, 0);
    ticks(2);
    chk("R4 still low", tmr_out, 0);
    ticks(1);
    chk("R4 end high", tmr_out, 1);
    gate = 1'b0;
    @(negedge clk);
    gate = 1'b1;
    @(negedge clk);
    chk("R8 mode1 retrigger", tmr_out, 0);
    ticks(3);
    chk("R8 mode1 retrigger end", tmr_out, 1);
  endtask

  task automatic t_mode2;
    gate = 1'b1;
    wr_ctl(cw(3, 2));
    load16(16'd4);
    chk("R5 after load", tmr_out, 1);
    for (int k = 1; k <= 8; k++) begin
      ticks(1);
      chk("R5 rate pattern", tmr_out, ((k % 4) == 3) ? 0 : 1);
    end
    ticks(3);
    chk("R5 low slot", tmr_out, 0);
    gate = 1'b0;
    #1;
    chk("R7 mode2 gate low", tmr_out, 1);
    @(negedge clk);
    gate = 1'b1;
    @(negedge clk);
    chk("R8 mode2 restart", tmr_out, 1);
    ticks(3);
    chk("R8 mode2 restart period", tmr_out, 0);
    ticks(2);
    gate = 1'b0;
    @(negedge clk);
    gate = 1'b1;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    ticks(3);
    chk("R8 restart beats tick", tmr_out, 0);
  endtask

  task automatic t_mode3;
    int v;
    gate = 1'b1;
    wr_ctl(cw(3, 3));
    load16(16'd5);
    for (int k = 1; k <= 10; k++) begin
      ticks(1);
      chk("R6 odd square", tmr_out, ((k % 5) < 3) ? 1 : 0);
    end
    ticks(3);
    chk("R6 low phase", tmr_out, 0);
    wr_ctl(8'h00);
    rd16(v);
    chk("R10 square readback el3", v, 4);
    ticks(1);
    wr_ctl(8'h00);
    rd16(v);
    chk("R10 square readback el4", v, 2);
    chk("R6 still low", tmr_out, 0);
    gate = 1'b0;
    #1;
    chk("R7 mode3 gate low", tmr_out, 1);
    @(negedge clk);
    gate = 1'b1;
    @(negedge clk);
    ticks(3);
    chk("R8 mode3 restart", tmr_out, 0);
    wr_ctl(cw(3, 7));
    load16(16'd6);
    for (int k = 1; k <= 12; k++) begin
      ticks(1);
      chk("R6 even square via alias R11", tmr_out, ((k % 6) < 3) ? 1 : 0);
    end
  endtask

  task automatic t_mode45;
    wr_ctl(cw(3, 4));
    chk("R13 mode4 initial", tmr_out, 1);
    load16(16'd3);
    ticks(2);
    chk("R9 before strobe", tmr_out, 1);
    ticks(1);
    chk("R9 strobe low", tmr_out, 0);
    ticks(1);
    chk("R9 strobe one tick", tmr_out, 1);
    ticks(5);
    chk("R9 no second strobe", tmr_out, 1);
    gate = 1'b0;
    wr_ctl(cw(3, 5));
    load16(16'd2);
    ticks(4);
    chk("R9 mode5 waits", tmr_out, 1);
    gate = 1'b1;
    @(negedge clk);
    ticks(1);
    chk("R9 mode5 counting", tmr_out, 1);
    ticks(1);
    chk("R9 mode5 strobe", tmr_out, 0);
    ticks(1);
    chk("R9 mode5 after strobe", tmr_out, 1);
  endtask

  task automatic t_latch;
    int v;
    wr_ctl(cw(3, 0));
    load16(16'd100);
    ticks(10);
    wr_ctl(8'h00);
    ticks(20);
    wr_ctl(8'h00);
    rd16(v);
    chk("R12 second latch ignored", v, 90);
    rd16(v);
    chk("R12 live after latch read", v, 70);
    wr_ctl(8'h00);
    ticks(5);
    rd16(v);
    chk("R12 new latch taken", v, 70);
  endtask

  task automatic t_ctrl_reset;
    wr_ctl(cw(3, 0));
    load16(16'd2);
    ticks(2);
    chk("R3 short count", tmr_out, 1);
    wr_ctl(cw(3, 0));
    chk("R13 control resets out", tmr_out, 0);
    ticks(10);
    chk("R13 no counting without load", tmr_out, 0);
    wr_ctl(cw(3, 2));
    ticks(10);
    chk("R13 mode2 idle high", tmr_out, 1);
  endtask

  task automatic t_collide;
    int v;
    wr_ctl(cw(3, 0));
    load16(16'd3);
    ticks(1);
    wr_cnt(8'd3);
    tick = 1'b1;
    wr_cnt(8'd0);
    tick = 1'b0;
    rd16(v);
    chk("R14 load beats tick", v, 3);
    ticks(2);
    chk("R14 low before N", tmr_out, 0);
    ticks(1);
    chk("R14 high at N", tmr_out, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0();
    t_full();
    t_mode1();
    t_mode2();
    t_mode3();
    t_mode45();
    t_latch();
    t_ctrl_reset();
    t_collide();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule